// File: doc/BRIEF.md
# Transceiver lane reset controller

This block sits in the fabric next to one serial transceiver lane and drives its two active-low reset inputs. One resets the analog and serializer section (PMA) and one resets the coding section (PCS). It also drives a separate transmit-PCS reset. A system reset reaches all three outputs at once, without waiting for a clock. Each output is released in step with a free-running fabric clock, and only after it has been held low for a minimum number of cycles. The controller never uses a receiver-recovered clock, because asserting the PMA reset stops that clock and the reset would then never be released.

The controller runs two recovery mechanisms in normal operation. The first counts per-word 8b10b decode-error strobes over a sliding window. When the count in the window reaches a threshold, it pulses the receive PCS reset so that the word aligner searches again for a comma. The second filters the transmit PLL lock input and pulses the transmit-PCS reset each time the filtered lock goes from unlocked to locked.

A rate change is handled without touching the reset pins. A sequencer writes a soft transmit-PCS reset bit to one, then writes the new serializer setting, then writes the soft reset bit back to zero. Each write goes over a valid/ready register port.

Top module: `xcvr_lane_rst_ctrl`

## Requirements
- R1: While `rst_n` is low, `pma_rst_n`, `pcs_rst_n` and `pcs_tx_rst_n` are all low. They go low within the same clock period in which `rst_n` falls, without waiting for a clock edge.
- R2: After `rst_n` rises, release is synchronized by two fabric-clock flops. Each reset output then stays low for at least HOLD_CYC further cycles and at most HOLD_CYC+3 cycles in total.
- R3: When the sliding-window error count reaches ERR_THRESH, `pcs_rst_n` is pulsed low for exactly HOLD_CYC cycles. A window holds the last WIN_LEN synchronized error samples, one per clock.
- R4: Errors that never reach ERR_THRESH within any WIN_LEN-cycle window cause no PCS reset. The window is emptied while the PCS reset pulse is active, so errors seen before or during the pulse do not count afterwards.
- R5: Each time the filtered PLL lock goes from 0 to 1, `pcs_tx_rst_n` is pulsed low for exactly HOLD_CYC cycles. `pcs_rst_n` is not affected.
- R6: The filtered lock changes only after LOCK_STABLE consecutive synchronized samples that disagree with it. A shorter lock glitch causes no pulse, and a loss of lock causes no pulse.
- R7: On an accepted rate request, `wr_valid` presents three writes in this order: address SOFT_RST_ADDR with data 1, then address SER_CFG_ADDR with the `rate_cfg` value captured at the request, then address SOFT_RST_ADDR with data 0. Address and data hold steady while `wr_ready` is low.
- R8: `rate_done` is a single-cycle pulse in the cycle after the third write is accepted. `rate_busy` is high from the cycle after the request until `rate_done` is high. The sequence never moves any reset output.
- R9: A `rate_req` seen while `rate_busy` is high is ignored and raises `rate_req_err` for one cycle, one cycle later.
- R10: `pma_rst_n` is driven only by the system reset path. Error trips, lock events and rate sequences never lower it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running fabric clock, independent of the lane's recovered clocks |
| rst_n | input | 1 | System reset, active low, may change at any time |
| pll_lock | input | 1 | Transmit PLL lock, asynchronous |
| err_strobe | input | 1 | Decode error for the current word, one word per clock, asynchronous |
| rate_req | input | 1 | Single-cycle request to start a rate change |
| rate_cfg | input | DATA_W | New serializer setting, sampled with `rate_req` |
| wr_ready | input | 1 | Register port accepts the current write |
| pma_rst_n | output | 1 | PMA reset, active low |
| pcs_rst_n | output | 1 | Receive PCS reset, active low |
| pcs_tx_rst_n | output | 1 | Transmit PCS reset, active low |
| wr_valid | output | 1 | Register write pending |
| wr_addr | output | ADDR_W | Register write address |
| wr_data | output | DATA_W | Register write data |
| rate_busy | output | 1 | Rate sequence in progress |
| rate_done | output | 1 | Rate sequence finished, one cycle |
| rate_req_err | output | 1 | Request arrived while busy, one cycle |

## Verification
The bench builds the block with HOLD_CYC=6, WIN_LEN=16, ERR_THRESH=4 and LOCK_STABLE=3. A window of 16 lets a short run space errors far enough apart that the window slides past old ones. It also lets a run trip the threshold and then show that errors left over after the pulse do not add to a new count. The short debounce and hold values allow several lock glitches, lock rises, lock falls and exact pulse-length counts within a few hundred cycles. Write stalls with a one-in-three ready pattern hold the sequencer in each of its write states for several cycles.

// File: rtl/xlrc_pkg.sv
`timescale 1ns/1ps
// Shared types for the lane reset controller.
package xlrc_pkg;
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SET,
        SQ_CFG,
        SQ_CLR,
        SQ_DONE
    } seq_state_t;
endpackage

// File: rtl/xlrc_sync2.sv
`timescale 1ns/1ps
// Two-flop synchronizer for W independent asynchronous levels.
// Assumes each bit is a slow level or a strobe at least one clock wide.
module xlrc_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         ok,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two-stage capture, cleared while the controller is in reset.
    always_ff @(posedge clk) begin
        if (!ok) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/xlrc_hold_pulse.sv
`timescale 1ns/1ps
// Reset pulse generator: active for exactly HOLD_CYC cycles after a start,
// and also for HOLD_CYC cycles after the controller leaves reset.
// Starts while active are ignored.
module xlrc_hold_pulse #(
    parameter int HOLD_CYC = 32
) (
    input  logic clk,
    input  logic ok,
    input  logic start,
    output logic active
);
    localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    logic [CW-1:0] cnt;

    // Count down the hold window, or arm it on a start request.
    always_ff @(posedge clk) begin
        if (!ok) begin
            active <= 1'b1;
            cnt    <= LAST;
        end else if (active) begin
            if (cnt == '0) active <= 1'b0;
            else           cnt    <= cnt - 1'b1;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= LAST;
        end
    end
endmodule

// File: rtl/xlrc_err_window.sv
`timescale 1ns/1ps
// Sliding-window error counter over the last WIN_LEN samples.
// trip is high while the count is at least ERR_THRESH. clr empties the window.
module xlrc_err_window #(
    parameter int WIN_LEN    = 256,
    parameter int ERR_THRESH = 16
) (
    input  logic clk,
    input  logic ok,
    input  logic clr,
    input  logic err,
    output logic trip
);
    localparam int CNT_W = $clog2(WIN_LEN + 1);
    localparam logic [CNT_W-1:0] THR = CNT_W'(ERR_THRESH);

    logic [WIN_LEN-1:0] hist;
    logic [CNT_W-1:0]   cnt;

    // Shift in the newest sample and keep the count of ones in step.
    always_ff @(posedge clk) begin
        if (!ok || clr) begin
            hist <= '0;
            cnt  <= '0;
        end else begin
            hist <= {hist[WIN_LEN-2:0], err};
            cnt  <= cnt + {{(CNT_W-1){1'b0}}, err}
                        - {{(CNT_W-1){1'b0}}, hist[WIN_LEN-1]};
        end
    end

    assign trip = (cnt >= THR);
endmodule

// File: rtl/xlrc_rate_seq.sv
`timescale 1ns/1ps
// Rate-change sequencer: three register writes over a valid/ready port
// (soft reset on, new serializer setting, soft reset off), then done.
// Requests while busy are dropped and flagged.
module xlrc_rate_seq
    import xlrc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter logic [ADDR_W-1:0] SOFT_RST_ADDR = 8'h10,
    parameter logic [ADDR_W-1:0] SER_CFG_ADDR  = 8'h14
) (
    input  logic              clk,
    input  logic              ok,
    input  logic              req,
    input  logic [DATA_W-1:0] cfg,
    input  logic              wr_ready,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              done,
    output logic              req_err
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    seq_state_t        state;
    logic [DATA_W-1:0] cfg_q;

    // Step through the writes, advancing only on an accepted write.
    always_ff @(posedge clk) begin
        if (!ok) begin
            state   <= SQ_IDLE;
            cfg_q   <= '0;
            req_err <= 1'b0;
        end else begin
            req_err <= req && (state != SQ_IDLE);
            case (state)
                SQ_IDLE: if (req) begin
                    cfg_q <= cfg;
                    state <= SQ_SET;
                end
                SQ_SET:  if (wr_ready) state <= SQ_CFG;
                SQ_CFG:  if (wr_ready) state <= SQ_CLR;
                SQ_CLR:  if (wr_ready) state <= SQ_DONE;
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Decode write port and status from the state.
    always_comb begin
        wr_valid = 1'b0;
        wr_addr  = SOFT_RST_ADDR;
        wr_data  = '0;
        case (state)
            SQ_SET: begin wr_valid = 1'b1; wr_data = ONE;   end
            SQ_CFG: begin wr_valid = 1'b1; wr_addr = SER_CFG_ADDR; wr_data = cfg_q; end
            SQ_CLR: begin wr_valid = 1'b1; end
            default: ;
        endcase
    end

    assign busy = (state != SQ_IDLE);
    assign done = (state == SQ_DONE);
endmodule

// File: rtl/xcvr_lane_rst_ctrl.sv
`timescale 1ns/1ps
// Lane reset controller top. Everything runs on a fabric clock that does not
// come from the lane's receiver. rst_n clears the reset synchronizer
// asynchronously so all reset outputs fall at once; every other register
// uses the synchronized reset.
module xcvr_lane_rst_ctrl #(
    parameter int HOLD_CYC    = 32,
    parameter int WIN_LEN     = 256,
    parameter int ERR_THRESH  = 16,
    parameter int LOCK_STABLE = 8,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter logic [ADDR_W-1:0] SOFT_RST_ADDR = 8'h10,
    parameter logic [ADDR_W-1:0] SER_CFG_ADDR  = 8'h14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pll_lock,
    input  logic              err_strobe,
    input  logic              rate_req,
    input  logic [DATA_W-1:0] rate_cfg,
    input  logic              wr_ready,
    output logic              pma_rst_n,
    output logic              pcs_rst_n,
    output logic              pcs_tx_rst_n,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              rate_busy,
    output logic              rate_done,
    output logic              rate_req_err
);
    localparam int LCW = (LOCK_STABLE > 1) ? $clog2(LOCK_STABLE) : 1;
    localparam logic [LCW-1:0] LOCK_LAST = LCW'(LOCK_STABLE - 1);

    logic rs1, sys_ok;
    logic lock_s, err_s;
    logic lock_f, lock_rise;
    logic [LCW-1:0] lock_cnt;
    logic trip, pma_act, rx_act, tx_act;

    // Reset synchronizer: asynchronous clear, release after two edges.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs1    <= 1'b0;
            sys_ok <= 1'b0;
        end else begin
            rs1    <= 1'b1;
            sys_ok <= rs1;
        end
    end

    xlrc_sync2 #(.W(2)) u_sync (
        .clk (clk),
        .ok  (sys_ok),
        .d   ({pll_lock, err_strobe}),
        .q   ({lock_s, err_s})
    );

    // Lock debounce: follow the input after LOCK_STABLE disagreeing samples.
    always_ff @(posedge clk) begin
        if (!sys_ok) begin
            lock_f    <= 1'b0;
            lock_cnt  <= '0;
            lock_rise <= 1'b0;
        end else if (lock_s == lock_f) begin
            lock_cnt  <= '0;
            lock_rise <= 1'b0;
        end else if (lock_cnt == LOCK_LAST) begin
            lock_f    <= lock_s;
            lock_cnt  <= '0;
            lock_rise <= lock_s;
        end else begin
            lock_cnt  <= lock_cnt + 1'b1;
            lock_rise <= 1'b0;
        end
    end

    xlrc_err_window #(.WIN_LEN(WIN_LEN), .ERR_THRESH(ERR_THRESH)) u_win (
        .clk  (clk),
        .ok   (sys_ok),
        .clr  (rx_act),
        .err  (err_s),
        .trip (trip)
    );

    xlrc_hold_pulse #(.HOLD_CYC(HOLD_CYC)) u_pma_hold (
        .clk (clk), .ok (sys_ok), .start (1'b0), .active (pma_act)
    );
    xlrc_hold_pulse #(.HOLD_CYC(HOLD_CYC)) u_rx_hold (
        .clk (clk), .ok (sys_ok), .start (trip), .active (rx_act)
    );
    xlrc_hold_pulse #(.HOLD_CYC(HOLD_CYC)) u_tx_hold (
        .clk (clk), .ok (sys_ok), .start (lock_rise), .active (tx_act)
    );

    xlrc_rate_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .SOFT_RST_ADDR(SOFT_RST_ADDR), .SER_CFG_ADDR(SER_CFG_ADDR)
    ) u_seq (
        .clk      (clk),
        .ok       (sys_ok),
        .req      (rate_req),
        .cfg      (rate_cfg),
        .wr_ready (wr_ready),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .busy     (rate_busy),
        .done     (rate_done),
        .req_err  (rate_req_err)
    );

    assign pma_rst_n    = sys_ok & ~pma_act;
    assign pcs_rst_n    = sys_ok & ~rx_act;
    assign pcs_tx_rst_n = sys_ok & ~tx_act;
endmodule

// File: rtl/xcvr_lane_rst_ctrl_chk.sv
`timescale 1ns/1ps
// Property checker for the lane reset controller, bound to the top module.
module xcvr_lane_rst_ctrl_chk #(
    parameter int HOLD_CYC = 32,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pma_rst_n,
    input logic              pcs_rst_n,
    input logic              pcs_tx_rst_n,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              rate_busy,
    input logic              rate_done,
    input logic              rate_req_err
);
    logic [15:0] rx_low, tx_low;

    // Saturating counts of consecutive low cycles on each PCS reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_low <= '0;
            tx_low <= '0;
        end else begin
            rx_low <= pcs_rst_n    ? '0 : ((rx_low == 16'hFFFF) ? rx_low : rx_low + 1'b1);
            tx_low <= pcs_tx_rst_n ? '0 : ((tx_low == 16'hFFFF) ? tx_low : tx_low + 1'b1);
        end
    end

    AST_RX_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pcs_rst_n) |-> rx_low >= 16'(HOLD_CYC)); // R3
    AST_TX_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pcs_tx_rst_n) |-> tx_low >= 16'(HOLD_CYC)); // R5
    AST_WR_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rate_done |=> !rate_done); // R8
    AST_REQ_ERR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rate_req_err |-> $past(rate_busy)); // R9
    AST_PMA_SYS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        pma_rst_n |=> pma_rst_n); // R10
endmodule

bind xcvr_lane_rst_ctrl xcvr_lane_rst_ctrl_chk #(
    .HOLD_CYC(HOLD_CYC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pma_rst_n    (pma_rst_n),
    .pcs_rst_n    (pcs_rst_n),
    .pcs_tx_rst_n (pcs_tx_rst_n),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .rate_busy    (rate_busy),
    .rate_done    (rate_done),
    .rate_req_err (rate_req_err)
);

// File: tb/xcvr_lane_rst_ctrl_tb.sv
`timescale 1ns/1ps
// Bench: behavioural per-clock reference model plus directed scenario checks.
module xcvr_lane_rst_ctrl_tb;
    localparam int HOLD = 6;
    localparam int WIN  = 16;
    localparam int THR  = 4;
    localparam int LST  = 3;
    localparam int AW   = 8;
    localparam int DW   = 16;
    localparam logic [AW-1:0] SOFT = 8'h21;
    localparam logic [AW-1:0] SER  = 8'h22;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pll_lock = 1'b0, err_strobe = 1'b0, rate_req = 1'b0, wr_ready = 1'b1;
    logic [DW-1:0] rate_cfg = '0;
    logic pma_rst_n, pcs_rst_n, pcs_tx_rst_n, wr_valid, rate_busy, rate_done, rate_req_err;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    int total = 0, bad = 0;
    bit checking = 0, finished = 0, stall = 0;
    int pma_low = 0, rx_low = 0, tx_low = 0, err_seen = 0, done_seen = 0;
    int wcount = 0;
    int wlog_a[16], wlog_d[16];

    always #5 clk = ~clk;

    xcvr_lane_rst_ctrl #(
        .HOLD_CYC(HOLD), .WIN_LEN(WIN), .ERR_THRESH(THR), .LOCK_STABLE(LST),
        .ADDR_W(AW), .DATA_W(DW), .SOFT_RST_ADDR(SOFT), .SER_CFG_ADDR(SER)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .pll_lock(pll_lock), .err_strobe(err_strobe),
        .rate_req(rate_req), .rate_cfg(rate_cfg), .wr_ready(wr_ready),
        .pma_rst_n(pma_rst_n), .pcs_rst_n(pcs_rst_n), .pcs_tx_rst_n(pcs_tx_rst_n),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .rate_busy(rate_busy), .rate_done(rate_done), .rate_req_err(rate_req_err)
    );

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int m_rs1 = 0, m_rs2 = 0, m_e1 = 0, m_e2 = 0, m_l1 = 0, m_l2 = 0;
    int m_lf = 0, m_lcnt = 0, m_rise = 0;
    int pact[3], pcnt[3];
    int hq[$];
    int sq = 0, sq_cfg = 0, m_rerr = 0;

    always @(posedge clk) begin
        int ok_o, ones, trip, rise_o, l2o, e2o;
        int pst[3];
        if (!rst_n) begin m_rs1 = 0; m_rs2 = 0; end
        ok_o = m_rs2;
        if (ok_o == 0) begin
            m_e1 = 0; m_e2 = 0; m_l1 = 0; m_l2 = 0;
            m_lf = 0; m_lcnt = 0; m_rise = 0;
            hq.delete(); repeat (WIN) hq.push_back(0);
            for (int i = 0; i < 3; i++) begin pact[i] = 1; pcnt[i] = HOLD - 1; end
            sq = 0; sq_cfg = 0; m_rerr = 0;
        end else begin
            ones = 0;
            foreach (hq[i]) ones += hq[i];
            trip = (ones >= THR);
            rise_o = m_rise; l2o = m_l2; e2o = m_e2;
            if (pact[1] != 0) begin hq.delete(); repeat (WIN) hq.push_back(0); end
            else begin void'(hq.pop_front()); hq.push_back(e2o); end
            m_e2 = m_e1; m_e1 = int'(err_strobe);
            if (l2o == m_lf) begin m_lcnt = 0; m_rise = 0; end
            else if (m_lcnt == LST - 1) begin m_lf = l2o; m_lcnt = 0; m_rise = l2o; end
            else begin m_lcnt++; m_rise = 0; end
            m_l2 = m_l1; m_l1 = int'(pll_lock);
            pst[0] = 0; pst[1] = trip; pst[2] = rise_o;
            for (int i = 0; i < 3; i++) begin
                if (pact[i] != 0) begin
                    if (pcnt[i] == 0) pact[i] = 0; else pcnt[i]--;
                end else if (pst[i] != 0) begin
                    pact[i] = 1; pcnt[i] = HOLD - 1;
                end
            end
            m_rerr = (rate_req && sq != 0) ? 1 : 0;
            case (sq)
                0: if (rate_req) begin sq_cfg = int'(rate_cfg); sq = 1; end
                1, 2, 3: if (wr_ready) sq++;
                default: sq = 0;
            endcase
        end
        if (rst_n) begin m_rs2 = m_rs1; m_rs1 = 1; end
    end

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        int okn, ev, ea, ed;
        if (checking) begin
            okn = (rst_n && m_rs2 != 0) ? 1 : 0;
            chk("R10 pma_rst_n", int'(pma_rst_n), okn & (pact[0] == 0 ? 1 : 0));
            chk("R3 pcs_rst_n", int'(pcs_rst_n), okn & (pact[1] == 0 ? 1 : 0));
            chk("R5 pcs_tx_rst_n", int'(pcs_tx_rst_n), okn & (pact[2] == 0 ? 1 : 0));
            ev = (sq >= 1 && sq <= 3) ? 1 : 0;
            chk("R7 wr_valid", int'(wr_valid), ev);
            if (ev != 0) begin
                ea = (sq == 2) ? int'(SER) : int'(SOFT);
                ed = (sq == 1) ? 1 : ((sq == 2) ? sq_cfg : 0);
                chk("R7 wr_addr", int'(wr_addr), ea);
                chk("R7 wr_data", int'(wr_data), ed);
            end
            chk("R8 rate_busy", int'(rate_busy), sq != 0 ? 1 : 0);
            chk("R8 rate_done", int'(rate_done), sq == 4 ? 1 : 0);
            chk("R9 rate_req_err", int'(rate_req_err), m_rerr);
            if (!pma_rst_n)    pma_low++;
            if (!pcs_rst_n)    rx_low++;
            if (!pcs_tx_rst_n) tx_low++;
            if (rate_req_err)  err_seen++;
            if (rate_done)     done_seen++;
            if (wr_valid && wr_ready && wcount < 16) begin
                wlog_a[wcount] = int'(wr_addr);
                wlog_d[wcount] = int'(wr_data);
                wcount++;
            end
        end
    end

    // Ready pattern: always ready, or one cycle in three when stalling.
    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk); #2;
            cyc++;
            wr_ready = stall ? ((cyc % 3) == 2) : 1'b1;
        end
    end

    task automatic step(int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic pulse_req(logic [DW-1:0] v);
        rate_cfg = v; rate_req = 1'b1;
        step(1);
        rate_req = 1'b0;
    endtask

    initial begin
        int a, b, c;
        step(5);
        checking = 1;
        a = pma_low; b = rx_low; c = tx_low;
        rst_n = 1'b1;
        step(30);
        // R2: release holds each output low for HOLD..HOLD+3 cycles
        chk("R2 pma low cycles in range", ((pma_low - a) >= HOLD && (pma_low - a) <= HOLD + 3) ? 1 : 0, 1);
        chk("R2 pcs low cycles in range", ((rx_low - b) >= HOLD && (rx_low - b) <= HOLD + 3) ? 1 : 0, 1);
        chk("R2 tx low cycles in range", ((tx_low - c) >= HOLD && (tx_low - c) <= HOLD + 3) ? 1 : 0, 1);

        a = pma_low;
        // R4: six errors, ten cycles apart, never four inside one window
        b = rx_low;
        for (int i = 0; i < 6; i++) begin
            err_strobe = 1'b1; step(1); err_strobe = 1'b0; step(9);
        end
        step(10);
        chk("R4 spaced errors no pcs reset", rx_low - b, 0);

        // R3 and R4: six back-to-back errors trip once; leftovers are cleared,
        // then three more errors must not trip again
        b = rx_low;
        err_strobe = 1'b1; step(6); err_strobe = 1'b0;
        step(20);
        err_strobe = 1'b1; step(3); err_strobe = 1'b0;
        step(25);
        chk("R3 burst gives one pcs pulse of HOLD cycles", rx_low - b, HOLD);

        // R6: lock glitch of two cycles is filtered
        c = tx_low;
        pll_lock = 1'b1; step(2); pll_lock = 1'b0;
        step(15);
        chk("R6 short lock glitch no tx reset", tx_low - c, 0);

        // R5: stable lock rise pulses the transmit reset only
        b = rx_low; c = tx_low;
        pll_lock = 1'b1; step(30);
        chk("R5 lock rise tx pulse length", tx_low - c, HOLD);
        chk("R5 lock rise leaves pcs_rst_n high", rx_low - b, 0);

        // R6: loss of lock gives no pulse
        c = tx_low;
        pll_lock = 1'b0; step(30);
        chk("R6 lock fall no tx reset", tx_low - c, 0);

        // R7, R8, R9: stalled sequence with a second request while busy
        a = pma_low; b = rx_low; c = tx_low;
        wcount = 0; err_seen = 0; done_seen = 0;
        stall = 1;
        pulse_req(16'hBEEF);
        step(3);
        pulse_req(16'h1234);
        step(40);
        chk("R7 three writes", wcount, 3);
        chk("R7 write0 addr", wlog_a[0], int'(SOFT));
        chk("R7 write0 data", wlog_d[0], 1);
        chk("R7 write1 addr", wlog_a[1], int'(SER));
        chk("R7 write1 data", wlog_d[1], 16'hBEEF);
        chk("R7 write2 addr", wlog_a[2], int'(SOFT));
        chk("R7 write2 data", wlog_d[2], 0);
        chk("R9 busy request flagged once", err_seen, 1);
        chk("R8 one done pulse", done_seen, 1);
        chk("R8 sequence leaves pins alone", (pma_low - a) + (rx_low - b) + (tx_low - c), 0);

        // R7: second sequence without stalls
        stall = 0;
        step(2);
        pulse_req(16'h00A5);
        step(10);
        chk("R7 second sequence writes", wcount, 6);
        chk("R7 second cfg data", wlog_d[4], 16'h00A5);
        chk("R8 second done pulse", done_seen, 2);

        // R1: asynchronous assertion between clock edges
        @(posedge clk); #2;
        rst_n = 1'b0;
        #1;
        chk("R1 pma low before next edge", int'(pma_rst_n), 0);
        chk("R1 pcs low before next edge", int'(pcs_rst_n), 0);
        chk("R1 tx low before next edge", int'(pcs_tx_rst_n), 0);
        step(3);
        rst_n = 1'b1;
        step(30);
        chk("R10 pma high after second release", int'(pma_rst_n), 1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule